// File: doc/BRIEF.md
# Modulo-Count PWM Channel

This block produces a pulse-width-modulated output from an up-counter that wraps at a programmable modulo value and from one output-compare channel. The count runs from zero up to the modulo value, emits a one-cycle overflow strobe, and returns to zero on the next cycle. The overflow drives the pin to its active level, which starts a pulse. A compare match on the live compare value drives it back to its inactive level. A polarity input sets which level counts as active, so the same compare setting gives either a high-true or a low-true pulse.

Software-facing values reach the block as plain inputs: a modulo value, a compare value, a polarity bit and a run enable. The compare value is unbuffered. A new value applies from the next count, so a value written part-way through a period can drop the compare event for that period. While the enable is low the counter rests at zero and the pin sits at its inactive level. Raising the enable starts a fresh period at count zero.

Top module: `pwm_modulo_channel`

## Requirements
- R1: With the enable high, `ovf_o` is high for exactly the cycles in which the count equals `mod_i`, and the count is zero on the following cycle. The period is therefore `mod_i`+1 cycles. When `mod_i` is 0, `ovf_o` is high on every enabled cycle.
- R2: With the enable high and fixed settings, let k be the number of cycles since the last overflow, where the first enabled cycle is k = 0. The pin is at its active level exactly when k < `cmp_i`, so the pulse lasts `cmp_i` cycles.
- R3: `pol_i` = 0 makes high the active level, so the pin is cleared at compare. `pol_i` = 1 makes low the active level, so the pin is set at compare. The inactive level always equals `pol_i`.
- R4: A compare value of 0 gives a pulse of zero width, and the pin stays at its inactive level for the whole period.
- R5: A compare value greater than `mod_i` never matches, and the pin stays at its active level for the whole period.
- R6: While `en_i` is low, `pwm_o` equals `pol_i` in the same cycle, `ovf_o` is low, and the count is held at zero. The first cycle after `en_i` rises is k = 0 of a new period.
- R7: A compare value changed during a period is matched against the following counts of that same period. If the count has already passed the new value, there is no compare event in that period: an active pin stays active until the overflow, and an inactive pin stays inactive until the overflow.
- R8: While `rst_n` is low, and after it is released with the enable low, `pwm_o` equals `pol_i` and `ovf_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Run enable for the counter and the pin |
| mod_i | input | CNT_W | Modulo value, the last count of each period |
| cmp_i | input | CNT_W | Compare value, the end of the pulse |
| pol_i | input | 1 | Polarity: 0 gives a high-true pulse, 1 gives a low-true pulse |
| pwm_o | output | 1 | PWM output pin |
| ovf_o | output | 1 | One-cycle overflow strobe that marks each period boundary |

## Verification
The bench sweeps every modulo value and every compare value of a 4-bit configuration under both polarities, and runs each setting for two full periods. This sweep separates the ordinary pulse from the zero-width case, from the full-period case where the compare value exceeds the modulo, and from the one-cycle period where the modulo is zero. Separate runs lower and raise the compare value part-way through a period, which shows whether a passed compare value is skipped until the next overflow. A mid-run drop of the enable checks that the pin returns to its inactive level immediately and that a new period starts at count zero. Reset is checked with the enable low.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    POL_HIGH_TRUE = 1'b0,
    POL_LOW_TRUE  = 1'b1
  } pol_e;

  // Pin level for a given polarity and pulse state.
  function automatic logic pin_level(input logic pol, input logic active);
    return pol ^ active;
  endfunction

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_mod_counter.sv
module pwm_mod_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign ovf    = en && (cnt_q == mod_val);
  assign cnt_ce = en || (cnt_q != '0);

  always_comb begin
    if (!en || ovf) cnt_d = '0;
    else            cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R1: the count restarts at zero after each overflow
  p_wrap_after_ovf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0));

  // R1: the count advances by one between overflows
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ovf) |=> (cnt_q == $past(cnt_q) + STEP));

  // R6: a disabled counter rests at zero
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_cmp_match.sv
module pwm_cmp_match #(
  parameter int CNT_W = 8
) (
  input  logic             en,
  input  logic             ovf,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             hit,
  output logic             cmp_nonzero
);

  // Look one count ahead so the pin changes on the cycle that shows the matching count.
  logic [CNT_W:0] next_cnt;

  assign next_cnt    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign hit         = en && !ovf && (next_cnt == {1'b0, cmp_val});
  assign cmp_nonzero = |cmp_val;

endmodule

// File: rtl/pwm_pin_ctrl.sv
module pwm_pin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ovf,
  input  logic hit,
  input  logic cmp_nonzero,
  output logic act_q
);

  logic act_d;

  always_comb begin
    if (!en || ovf) act_d = cmp_nonzero;  // preload the level for count zero
    else if (hit)   act_d = 1'b0;
    else            act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  // R2: a compare match ends the pulse
  p_match_ends_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !act_q);

  // R4: a zero compare value leaves the pulse off after overflow
  p_zero_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cmp_nonzero) |=> !act_q);

  // R2: an overflow with a nonzero compare value starts a pulse
  p_ovf_starts_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cmp_nonzero) |=> act_q);

endmodule

// File: rtl/pwm_modulo_channel.sv
module pwm_modulo_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             pol_i,
  output logic             pwm_o,
  output logic             ovf_o
);

  import pwm_pkg::*;

  logic             rst_n_int;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf;
  logic             hit;
  logic             cmp_nz;
  logic             act_q;

  pwm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pwm_mod_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (en_i),
    .mod_val (mod_i),
    .cnt_q   (cnt_q),
    .ovf     (ovf)
  );

  pwm_cmp_match #(.CNT_W(CNT_W)) u_match (
    .en          (en_i),
    .ovf         (ovf),
    .cnt_q       (cnt_q),
    .cmp_val     (cmp_i),
    .hit         (hit),
    .cmp_nonzero (cmp_nz)
  );

  pwm_pin_ctrl u_pin (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .en          (en_i),
    .ovf         (ovf),
    .hit         (hit),
    .cmp_nonzero (cmp_nz),
    .act_q       (act_q)
  );

  assign pwm_o = pin_level(pol_i, en_i && act_q);
  assign ovf_o = ovf;

  // R5: a compare value above the modulo keeps the pulse on through the period
  p_full_period_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (en_i && !ovf && (cmp_i > mod_i) && (cnt_q <= mod_i) && act_q) |=> act_q);

endmodule

// File: tb/pwm_modulo_channel_bench.sv
module pwm_modulo_channel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         en_i;
  logic [W-1:0] mod_i;
  logic [W-1:0] cmp_i;
  logic         pol_i;
  logic         pwm_o;
  logic         ovf_o;

  int checks;
  int fails;

  pwm_modulo_channel #(.CNT_W(W)) u_pwm_modulo_channel (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .mod_i (mod_i),
    .cmp_i (cmp_i),
    .pol_i (pol_i),
    .pwm_o (pwm_o),
    .ovf_o (ovf_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  // Sample at count k of a run with the given modulo, compare and polarity.
  task automatic sample(input int k, input int m, input int c, input logic p, input string req);
    int ph;
    ph = k % (m + 1);
    chk(pwm_o, p ^ (ph < c), req, $sformatf("pin m=%0d c=%0d p=%0b k=%0d", m, c, p, k));
    chk(ovf_o, (ph == m), "R1", $sformatf("ovf m=%0d k=%0d", m, k));
  endtask

  task automatic start(input int m, input int c, input logic p);
    @(negedge clk);
    en_i  = 1'b0;
    mod_i = W'(m);
    cmp_i = W'(c);
    pol_i = p;
    @(negedge clk);
    en_i = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    en_i   = 1'b0;
    mod_i  = W'(5);
    cmp_i  = W'(2);
    pol_i  = 1'b1;

    // R8: reset state
    #(CLK_PERIOD * 2 + 1);
    chk(pwm_o, 1'b1, "R8", "pin in reset");
    chk(ovf_o, 1'b0, "R8", "ovf in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(pwm_o, 1'b1, "R8", "pin after release");
    chk(ovf_o, 1'b0, "R8", "ovf after release");

    // R2 R3 R4 R5 R1: full sweep
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < (1 << W); m++) begin
        for (int c = 0; c < (1 << W); c++) begin
          string tag;
          if (c == 0)      tag = "R4";
          else if (c > m)  tag = "R5";
          else if (p == 1) tag = "R3";
          else             tag = "R2";
          start(m, c, p[0]);
          for (int k = 0; k < 2 * (m + 1) + 1; k++) begin
            #1;
            sample(k, m, c, p[0], tag);
            @(negedge clk);
          end
          en_i = 1'b0;
          #1;
          chk(pwm_o, p[0], "R6", "pin at disable");
          chk(ovf_o, 1'b0, "R6", "ovf at disable");
        end
      end
    end

    // R6: drop enable mid-run, then restart at count zero
    start(7, 3, 1'b1);
    for (int k = 0; k < 5; k++) begin
      #1; sample(k, 7, 3, 1'b1, "R6"); @(negedge clk);
    end
    en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(pwm_o, 1'b1, "R6", "pin while disabled");
      chk(ovf_o, 1'b0, "R6", "ovf while disabled");
      @(negedge clk);
    end
    en_i = 1'b1;
    for (int k = 0; k < 12; k++) begin
      #1; sample(k, 7, 3, 1'b1, "R6"); @(negedge clk);
    end
    en_i = 1'b0;

    // R7: lower the compare value below the next count while the pulse is on
    start(9, 6, 1'b0);
    for (int k = 0; k < 20; k++) begin
      logic exp;
      #1;
      if (k < 10) exp = (k < 4) ? (k < 6) : 1'b1;
      else        exp = ((k % 10) < 2);
      chk(pwm_o, exp, "R7", $sformatf("lowered compare k=%0d", k));
      if (k == 3) cmp_i = W'(2);
      @(negedge clk);
    end
    en_i = 1'b0;

    // R7: raise the compare value after the match: no second pulse in the period
    start(9, 3, 1'b0);
    for (int k = 0; k < 20; k++) begin
      logic exp;
      #1;
      if (k < 10) exp = (k < 3);
      else        exp = ((k % 10) < 8);
      chk(pwm_o, exp, "R7", $sformatf("raised compare k=%0d", k));
      if (k == 5) cmp_i = W'(8);
      @(negedge clk);
    end
    en_i = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule